// File: doc/BRIEF.md
# Synchronous Flow-Through Static Memory with Address-Load Strobe

This block is a single-port synchronous static memory. Each word is split into byte lanes; every lane carries eight data bits and one parity bit, and each lane has its own active-low write enable. The address, write data, chip enable, address-load strobe and lane write enables are all registered on the rising clock edge. Read data is not registered again: it flows from the storage array to the output during the same cycle that the address was captured in.

The address-load strobe decides where the address comes from. When the strobe is low at an edge, chip enable is examined. With chip enable high the memory becomes deselected. With chip enable low it loads the external address and starts a read or a write. When the strobe is high, the address loaded earlier is reused and chip enable is ignored. A deselected memory stays deselected until the next strobe. The output enable is not clocked. It gates the pad driver directly, and the driver is never turned on during a write. The full configuration has 16 address bits and 8 lanes. The default address width is smaller so that the array stays small when elaborated.

The controller is a three-state machine: DESEL (no cycle in progress), READ and WRITE. The transitions are as follows. T_DESEL is taken from any state when the strobe is low and chip enable is high. T_LOAD_RD and T_LOAD_WR are taken from any state when the strobe and chip enable are both low, with all lane enables high or with at least one lane enable low. T_HOLD_RD and T_HOLD_WR are taken from READ or WRITE when the strobe is high, using the same lane-enable test. T_IDLE keeps DESEL while the strobe is high. Reset puts the machine in DESEL.

Top module: `sfsram_top`

## Requirements
- R1: After reset the memory is in DESEL and `rd_drive` is 0 (pad at high impedance), whatever the level of `oe_n`.
- R2: An edge with `strobe_n`=0 and `ce_n`=1 enters DESEL. `rd_drive` goes to 0, and no lane is written at that edge, even if write enables are low.
- R3: An edge with `strobe_n`=0, `ce_n`=0 and all `we_n` bits 1 loads `addr` and starts a read. After that edge, `rd_data` shows the stored word at that address within the same cycle.
- R4: An edge with `strobe_n`=0, `ce_n`=0 and any `we_n` bit 0 loads `addr` and writes at that edge only the lanes whose enable is 0. Lane k covers data bits 8k..8k+7 and parity bit 64+k of `wr_data` and `rd_data` (bits 63:0 are data and bits 71:64 are parity).
- R5: An edge with `strobe_n`=1 while in READ or WRITE reuses the held address, ignores both `addr` and `ce_n`, and performs a write if any `we_n` bit is 0 and a read otherwise.
- R6: An edge with `strobe_n`=1 while in DESEL stays in DESEL, and lane write enables have no effect.
- R7: `rd_drive` is 1 exactly when the memory is in READ and `oe_n` is 0. `oe_n` acts without a clock edge. `rd_data` is 0 whenever `rd_drive` is 0.
- R8: During WRITE, `rd_drive` is 0 whatever the level of `oe_n`.
- R9: While consecutive edges keep READ with `strobe_n`=1, the read word does not change, because it changes only after an edge that loads a new address or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller state |
| strobe_n | input | 1 | Address-load strobe, active low |
| ce_n | input | 1 | Chip enable, active low, examined only while the strobe is low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| we_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*9 | Write word: data lanes in the low bits, parity bits on top |
| rd_data | output | LANES*9 | Read word, same layout as the write word, 0 when not driven |
| rd_drive | output | 1 | Pad driver enable for the tri-state data bus |

## Verification
The bench fills every address of a 256-word configuration with an arithmetic pattern and reads it all back. It then merges single-lane and mixed-lane writes into its model. A lane decode that is off by one, or that misplaces parity bits, would corrupt neighbouring bytes or parity. The bench changes `addr` and `ce_n` while the strobe is high. A design that reloaded the address there would read or write the wrong word, and one that honoured chip enable there would drop out of a read. It also tries writes while deselected and while deselecting, which a design that ignored DESEL would let through. It toggles `oe_n` between edges and during writes, which catches a registered output enable or a bus driven during a write.

// File: rtl/sfsram_pkg.sv
package sfsram_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } sfsram_state_e;

    // Bits stored per lane besides the data byte
    localparam int PARITY_PER_LANE = 1;

endpackage

// File: rtl/sfsram_ctrl.sv
module sfsram_ctrl
    import sfsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              ce_n,
    input  logic [LANES-1:0]  we_n,
    input  logic [ADDR_W-1:0] addr,
    output sfsram_state_e     state_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_addr
);

    sfsram_state_e state_d;
    logic          any_wr;
    logic          load_addr;

    assign any_wr    = ~(&we_n);
    assign load_addr = ~strobe_n & ~ce_n;

    // Next-state decision
    always_comb begin
        state_d = ST_DESEL;
        if (!strobe_n) begin
            if (ce_n) begin
                state_d = ST_DESEL;                       // T_DESEL
            end else begin
                state_d = any_wr ? ST_WRITE : ST_READ;    // T_LOAD_WR / T_LOAD_RD
            end
        end else begin
            unique case (state_q)
                ST_DESEL: state_d = ST_DESEL;             // T_IDLE
                ST_READ,
                ST_WRITE: state_d = any_wr ? ST_WRITE : ST_READ; // T_HOLD_WR / T_HOLD_RD
                default:  state_d = ST_DESEL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Held address register (contents undefined until first load)
    always_ff @(posedge clk) begin
        if (load_addr) begin
            addr_q <= addr;
        end
    end

    // Write issue at this edge
    always_comb begin
        wr_go   = (state_d == ST_WRITE);
        wr_addr = strobe_n ? addr_q : addr;
    end

    // R2
    desel_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && ce_n) |=> (state_q == ST_DESEL));

    // R3
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !ce_n) |=> (addr_q == $past(addr)));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> $stable(addr_q));

    // R6
    desel_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && state_q == ST_DESEL) |=> (state_q == ST_DESEL));

endmodule

// File: rtl/sfsram_lane_bank.sv
module sfsram_lane_bank #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_go,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        we_n,
    input  logic [LANES*LANE_W-1:0] wr_lanes,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_lanes
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_go && !we_n[k]) begin
                store[wr_addr] <= wr_lanes[k*LANE_W +: LANE_W];
            end
        end

        // Flow-through read from the held address
        assign rd_lanes[k*LANE_W +: LANE_W] = store[rd_addr];
    end

endmodule

// File: rtl/sfsram_pad_gate.sv
module sfsram_pad_gate
    import sfsram_pkg::*;
#(
    parameter int WORD_W = 72
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sfsram_state_e       state_q,
    input  logic                oe_n,
    input  logic [WORD_W-1:0]   word_in,
    output logic [WORD_W-1:0]   word_out,
    output logic                drive
);

    always_comb begin
        drive    = (state_q == ST_READ) && !oe_n;
        word_out = drive ? word_in : '0;
    end

    // R8
    no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> !drive);

endmodule

// File: rtl/sfsram_top.sv
module sfsram_top
    import sfsram_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int LANES       = 8,
    parameter int LANE_DATA_W = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          strobe_n,
    input  logic                                          ce_n,
    input  logic                                          oe_n,
    input  logic [LANES-1:0]                              we_n,
    input  logic [ADDR_W-1:0]                             addr,
    input  logic [LANES*(LANE_DATA_W+PARITY_PER_LANE)-1:0] wr_data,
    output logic [LANES*(LANE_DATA_W+PARITY_PER_LANE)-1:0] rd_data,
    output logic                                          rd_drive
);

    localparam int LANE_W = LANE_DATA_W + PARITY_PER_LANE;
    localparam int WORD_W = LANES * LANE_W;
    localparam int DATA_W = LANES * LANE_DATA_W;

    sfsram_state_e     state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_lanes;
    logic [WORD_W-1:0] rd_lanes;
    logic [WORD_W-1:0] rd_word;

    sfsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .state_q  (state_q),
        .addr_q   (addr_q),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr)
    );

    // Bus layout (data low, parity high) to lane-packed layout and back
    for (genvar k = 0; k < LANES; k++) begin : g_map
        assign wr_lanes[k*LANE_W +: LANE_DATA_W] = wr_data[k*LANE_DATA_W +: LANE_DATA_W];
        assign wr_lanes[k*LANE_W + LANE_DATA_W]  = wr_data[DATA_W + k];
        assign rd_word[k*LANE_DATA_W +: LANE_DATA_W] = rd_lanes[k*LANE_W +: LANE_DATA_W];
        assign rd_word[DATA_W + k]                   = rd_lanes[k*LANE_W + LANE_DATA_W];
    end

    sfsram_lane_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
        .clk      (clk),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .we_n     (we_n),
        .wr_lanes (wr_lanes),
        .rd_addr  (addr_q),
        .rd_lanes (rd_lanes)
    );

    sfsram_pad_gate #(.WORD_W(WORD_W)) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .oe_n     (oe_n),
        .word_in  (rd_word),
        .word_out (rd_data),
        .drive    (rd_drive)
    );

    // R9
    rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && strobe_n && (&we_n)) |=> $stable(rd_word));

endmodule

// File: tb/sfsram_top_tb_top.sv
module sfsram_top_tb_top;

    localparam int AW    = 8;
    localparam int LN    = 8;
    localparam int WW    = 72;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [LN-1:0] we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] rd_data;
    logic          rd_drive;

    int total = 0;
    int bad   = 0;
    logic [WW-1:0] model [DEPTH];

    always #10 clk = ~clk;

    sfsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    // Lane value k holds 9 bits: low 8 go to data bits 8k.., bit 8 goes to bit 64+k
    function automatic logic [WW-1:0] pat(input int a, input int s);
        logic [WW-1:0] w = '0;
        for (int k = 0; k < LN; k++) begin
            logic [8:0] v = 9'((a * 37 + k * 11 + s * 101 + (a >> 3) * 5) & 9'h1ff);
            w[8*k +: 8] = v[7:0];
            w[64 + k]   = v[8];
        end
        return w;
    endfunction

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] nw,
                                            input logic [LN-1:0] wen);
        logic [WW-1:0] r = old;
        for (int k = 0; k < LN; k++) begin
            if (!wen[k]) begin
                r[8*k +: 8] = nw[8*k +: 8];
                r[64 + k]   = nw[64 + k];
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after a falling edge, sample 5 ns after the rising edge
    task automatic step(input logic sn, input logic cn, input logic [LN-1:0] wen,
                        input int a, input logic [WW-1:0] d);
        @(negedge clk);
        strobe_n = sn; ce_n = cn; we_n = wen; addr = AW'(a); wr_data = d;
        @(posedge clk);
        #5;
    endtask

    task automatic rd_at(input string req, input int a);
        step(1'b0, 1'b0, '1, a, '0);
        chk(req, {71'd0, rd_drive}, 72'd1);
        chk(req, rd_data, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state, oe_n low yet not driven
        chk("R1", {71'd0, rd_drive}, 72'd0);
        chk("R1", rd_data, '0);
        rst_n = 1'b1;
        step(1'b1, 1'b1, '1, 0, '0);
        chk("R1", {71'd0, rd_drive}, 72'd0);

        // R4/R8: full-word fill, bus never driven in writes with oe_n low
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = pat(a, 0);
            step(1'b0, 1'b0, '0, a, model[a]);
            chk("R8", {71'd0, rd_drive}, 72'd0);
        end
        // R3: sweep readback
        for (int a = 0; a < DEPTH; a++) rd_at("R3", a);

        // R4: single-lane and mixed-lane writes
        for (int k = 0; k < LN; k++) begin
            int a = 17 * k + 3;
            logic [LN-1:0] m = ~(LN'(1) << k);
            logic [WW-1:0] nw = pat(a, k + 1);
            step(1'b0, 1'b0, m, a, nw);
            model[a] = merge(model[a], nw, m);
            rd_at("R4", a);
            rd_at("R4", a + 1);
        end
        begin
            logic [LN-1:0] m = 8'b0101_1010;
            logic [WW-1:0] nw = pat(200, 9);
            step(1'b0, 1'b0, m, 200, nw);
            model[200] = merge(model[200], nw, m);
            rd_at("R4", 200);
        end

        // R5/R9: held read ignores addr and ce_n, output stays
        rd_at("R5", 40);
        for (int i = 0; i < 4; i++) begin
            step(1'b1, logic'(i[0]), '1, 90 + i, '0);
            chk("R5", {71'd0, rd_drive}, 72'd1);
            chk("R9", rd_data, model[40]);
        end

        // R5: held write lands at held address, not bus address
        rd_at("R5", 60);
        begin
            logic [WW-1:0] nw = pat(60, 33);
            step(1'b1, 1'b1, '0, 61, nw);
            chk("R8", {71'd0, rd_drive}, 72'd0);
            model[60] = nw;
            step(1'b1, 1'b0, '1, 62, '0);
            chk("R5", rd_data, model[60]);
        end
        rd_at("R5", 61);
        rd_at("R5", 60);

        // R7: oe_n acts between edges
        rd_at("R7", 70);
        #2 oe_n = 1'b1; #1;
        chk("R7", {71'd0, rd_drive}, 72'd0);
        chk("R7", rd_data, '0);
        #1 oe_n = 1'b0; #1;
        chk("R7", {71'd0, rd_drive}, 72'd1);
        chk("R7", rd_data, model[70]);

        // R8: write with oe_n high and low, never driven
        step(1'b0, 1'b0, 8'hFE, 71, pat(71, 5));
        model[71] = merge(model[71], pat(71, 5), 8'hFE);
        chk("R8", {71'd0, rd_drive}, 72'd0);
        #2 oe_n = 1'b1; #1;
        chk("R8", {71'd0, rd_drive}, 72'd0);
        #1 oe_n = 1'b0;
        rd_at("R4", 71);

        // R2: deselect with write enables low writes nothing
        step(1'b0, 1'b1, '0, 80, pat(80, 7));
        chk("R2", {71'd0, rd_drive}, 72'd0);
        // R6: strobe high while deselected: no write, stays deselected
        step(1'b1, 1'b0, '0, 80, pat(80, 8));
        chk("R6", {71'd0, rd_drive}, 72'd0);
        step(1'b1, 1'b0, '1, 81, '0);
        chk("R6", {71'd0, rd_drive}, 72'd0);
        chk("R6", rd_data, '0);
        rd_at("R2", 80);
        rd_at("R6", 80);

        // R2: deselect ends a read
        step(1'b0, 1'b1, '1, 80, '0);
        chk("R2", {71'd0, rd_drive}, 72'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule